// File: doc/BRIEF.md
# Dual-Buffer Transmit DMA Sequencer

This block moves bytes from memory to a serial transmitter through two host-programmed buffers, A and B. For each buffer the host gives a start address, a byte count and a status word that hands ownership to the sequencer. The sequencer reads memory in bursts of at most `BURST` bytes, stages each burst, and offers the bytes one at a time on a valid/ready byte port. When a buffer has been fully sent, ownership returns to the host and a completion flag is raised.

Buffer A can also run as a growing buffer for echoed characters. Here the host keeps adding bytes to memory and raises A's count while A is active. Between bursts the sequencer compares A's count with what it has already sent and transmits any new bytes. When A has nothing new and B is owned, B is sent to the end without interruption, and then polling of A resumes. A terminate command ends growing mode once every counted byte is out.

A memory bus error drops the failed burst, reports its start address and raises an interrupt. Memory traffic then stops until an end-of-interrupt write arrives. That write either discards the buffer or retries the same burst.

Top module: `dual_buf_txdma`

## Requirements
- R1: After reset, `mem_req`, `tx_valid` and `irq_o` are 0, and `own_o`, `done_o` and `berr_o` are all 0 (bit 0 is buffer A, bit 1 is buffer B in every two-bit output).
- R2: Host register map, written with `host_wr` for one cycle at `host_addr`: 0 A address, 1 A count, 2 A status, 3 B address, 4 B count, 5 B status, 6 command (bit 0 terminates A), 7 end-of-interrupt (bit 0 discards the buffer). In a status word, bit 0 gives ownership to the sequencer and bit 1 (A only) selects growing mode. A status write outside a pending error restarts the buffer with no bytes sent.
- R3: Each memory request asks for min(`BURST`, count − sent) bytes starting at address + sent. The request stays up with stable address and length until `mem_ack`.
- R4: Bytes leave `tx_data` in ascending address order. `tx_valid` and `tx_data` hold until `tx_ready`.
- R5: A buffer not in growing mode, once all counted bytes are accepted, has its `own_o` bit cleared and its `done_o` bit set.
- R6: In growing mode, A may start with a count of 0 and then issues no reads. Each raise of the count sends exactly the new bytes, and A stays owned.
- R7: When A has no unsent bytes and B is owned, all of B is sent with no A byte in between, even if A's count rises meanwhile. A's new bytes follow afterwards.
- R8: A terminate command takes effect only after every counted byte of A has been sent. A then loses ownership and growing mode, and `done_o[0]` is set.
- R9: A beat with `mem_rerr` set sends no byte of that burst. It raises `irq_o`, sets the buffer's `berr_o` bit, clears its `own_o` bit, and shows the burst start address on `err_addr_o`. No memory request is issued while any `berr_o` bit is set.
- R10: An end-of-interrupt write with bit 0 = 1 clears `irq_o` and `berr_o`, leaves the buffer unowned and not done, and sends none of its remaining bytes.
- R11: A status write with bit 0 = 1 during a pending error, followed by an end-of-interrupt write with bit 0 = 0, retries from the failed burst's start address. Bytes already sent are not sent again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_wr | input | 1 | Host register write strobe |
| host_addr | input | 3 | Host register index |
| host_wdata | input | HOST_W | Host write data |
| mem_req | output | 1 | Burst read request |
| mem_addr | output | ADDR_W | Burst start address |
| mem_len | output | LEN_W | Burst length in bytes |
| mem_ack | input | 1 | Request accepted |
| mem_rvalid | input | 1 | Read beat valid |
| mem_rdata | input | 8 | Read beat byte |
| mem_rerr | input | 1 | Bus error on this beat (ends the burst) |
| tx_valid | output | 1 | Transmit byte valid |
| tx_data | output | 8 | Transmit byte |
| tx_ready | input | 1 | Transmitter takes the byte |
| irq_o | output | 1 | Bus-error interrupt pending |
| own_o | output | 2 | Sequencer owns buffer (A bit 0, B bit 1) |
| done_o | output | 2 | Buffer completed |
| berr_o | output | 2 | Bus error on buffer |
| err_addr_o | output | ADDR_W | Start address of the last burst |

## Verification
A host write lands at the edge that ends its cycle. The next cycle is a selection cycle, and a memory request rises one edge later. The first byte of a burst appears only after all of its beats have arrived. Completion flags change two edges after the last accepted byte, and error flags change one edge after the errored beat. The scoreboard compares bytes in order as they are accepted, so it does not depend on exact latency. Status checks are sampled on the falling edge, either after the expected queue has drained plus a fixed margin or after `irq_o` is seen within a bounded wait. This places every sample after the last register that could still change.

// File: rtl/dbtx_pkg.sv
// Shared types and register indices for the dual-buffer transmit sequencer.
// Assumes a three-bit host register index.
package dbtx_pkg;
    typedef enum logic [1:0] {ST_PICK, ST_RUN, ST_ERR} seq_st_t;
    typedef enum logic [1:0] {BS_IDLE, BS_REQ, BS_FILL, BS_DRAIN} burst_st_t;
    localparam logic [2:0] REG_CMD = 3'd6;
    localparam logic [2:0] REG_EOI = 3'd7;
    localparam int unsigned REGS_PER_BUF = 3;
endpackage

// File: rtl/dbtx_bufctl.sv
// Per-buffer register and state holder: address, count, ownership, growing
// mode, terminate request, bytes-sent counter, completion and error flags.
// Assumes HOST_W >= ADDR_W and HOST_W >= CNT_W, and that events from the
// sequencer outrank host writes in the same cycle.
module dbtx_bufctl #(
    parameter int unsigned ADDR_W    = 16,
    parameter int unsigned CNT_W     = 16,
    parameter int unsigned HOST_W    = 16,
    parameter int unsigned LEN_W     = 5,
    parameter bit          APPEND_OK = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_base,
    input  logic              wr_cnt,
    input  logic              wr_stat,
    input  logic              wr_term,
    input  logic              wr_eoi,
    input  logic [HOST_W-1:0] wdata,
    input  logic              ev_adv,
    input  logic [LEN_W-1:0]  adv_len,
    input  logic              ev_complete,
    input  logic              ev_err,
    output logic [ADDR_W-1:0] base,
    output logic [CNT_W-1:0]  cnt,
    output logic [CNT_W-1:0]  sent,
    output logic              own,
    output logic              append,
    output logic              term,
    output logic              done,
    output logic              berr
);
    // Host writes first, then sequencer events, so events win on a clash.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base <= '0; cnt <= '0; sent <= '0;
            own <= 1'b0; append <= 1'b0; term <= 1'b0; done <= 1'b0; berr <= 1'b0;
        end else begin
            if (wr_base) base <= wdata[ADDR_W-1:0];
            if (wr_cnt)  cnt  <= wdata[CNT_W-1:0];
            if (wr_stat) begin
                own <= wdata[0];
                if (!berr) begin
                    append <= APPEND_OK && wdata[1];
                    sent   <= '0;
                    done   <= 1'b0;
                    term   <= 1'b0;
                end
            end
            if (APPEND_OK && wr_term) term <= 1'b1;
            if (wr_eoi && berr) begin
                berr <= 1'b0;
                if (wdata[0]) begin
                    own <= 1'b0; append <= 1'b0; term <= 1'b0;
                end
            end
            if (ev_adv) sent <= sent + CNT_W'(adv_len);
            if (ev_complete) begin
                own <= 1'b0; append <= 1'b0; term <= 1'b0; done <= 1'b1;
            end
            if (ev_err) begin
                own  <= 1'b0;
                berr <= 1'b1;
            end
        end
    end

    // R5
    complete_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ev_complete |=> (!own && done));
    // R9
    err_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ev_err |=> (berr && !own));
endmodule

// File: rtl/dbtx_burst.sv
// Burst engine: issues one read request, stages every returned beat, then
// offers the staged bytes in order on the transmit port. A beat flagged with
// a bus error ends the burst, and none of its bytes are transmitted.
// Assumes BURST >= 2 and that memory returns exactly the requested beats.
module dbtx_burst
    import dbtx_pkg::*;
#(
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned BURST  = 16,
    parameter int unsigned LEN_W  = $clog2(BURST + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [LEN_W-1:0]  start_len,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [LEN_W-1:0]  mem_len,
    input  logic              mem_ack,
    input  logic              mem_rvalid,
    input  logic [7:0]        mem_rdata,
    input  logic              mem_rerr,
    output logic              tx_valid,
    output logic [7:0]        tx_data,
    input  logic              tx_ready,
    output logic              idle,
    output logic              done_ok,
    output logic              fail
);
    localparam int unsigned IDX_W = $clog2(BURST);

    burst_st_t         st;
    logic [ADDR_W-1:0] addr_q;
    logic [LEN_W-1:0]  len_q;
    logic [LEN_W-1:0]  idx;
    logic [LEN_W-1:0]  idx_nx;
    logic [7:0]        stage [BURST];

    assign idx_nx   = idx + LEN_W'(1);
    assign idle     = (st == BS_IDLE);
    assign mem_req  = (st == BS_REQ);
    assign mem_addr = addr_q;
    assign mem_len  = len_q;
    assign tx_valid = (st == BS_DRAIN);
    assign tx_data  = stage[idx[IDX_W-1:0]];
    assign done_ok  = (st == BS_DRAIN) && tx_ready && (idx_nx == len_q);
    assign fail     = (st == BS_FILL) && mem_rvalid && mem_rerr;

    // Burst state machine: request, fill, drain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= BS_IDLE; addr_q <= '0; len_q <= '0; idx <= '0;
        end else begin
            unique case (st)
                BS_IDLE: if (start) begin
                    addr_q <= start_addr; len_q <= start_len; idx <= '0; st <= BS_REQ;
                end
                BS_REQ: if (mem_ack) st <= BS_FILL;
                BS_FILL: if (mem_rvalid) begin
                    if (mem_rerr) begin
                        st <= BS_IDLE;
                    end else if (idx_nx == len_q) begin
                        idx <= '0; st <= BS_DRAIN;
                    end else begin
                        idx <= idx_nx;
                    end
                end
                BS_DRAIN: if (tx_ready) begin
                    idx <= idx_nx;
                    if (idx_nx == len_q) st <= BS_IDLE;
                end
                default: st <= BS_IDLE;
            endcase
        end
    end

    // Staging store: captures each good beat at its slot.
    always_ff @(posedge clk) begin
        if (st == BS_FILL && mem_rvalid && !mem_rerr) stage[idx[IDX_W-1:0]] <= mem_rdata;
    end

    // R3
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_len)));
    // R3
    burst_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_len != '0 && mem_len <= LEN_W'(BURST)));
    // R4
    tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));
endmodule

// File: rtl/dual_buf_txdma.sv
// Top of the dual-buffer transmit sequencer. Decodes host writes, holds one
// state block per buffer, and between bursts picks the next action: go on
// with a running B buffer, send new bytes of A, release A, or start B.
// Assumes count writes arrive whole in one host cycle. Counts are read only
// in the selection cycle between bursts.
module dual_buf_txdma
    import dbtx_pkg::*;
#(
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned CNT_W  = 16,
    parameter int unsigned HOST_W = 16,
    parameter int unsigned BURST  = 16,
    parameter int unsigned LEN_W  = $clog2(BURST + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr,
    input  logic [2:0]        host_addr,
    input  logic [HOST_W-1:0] host_wdata,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [LEN_W-1:0]  mem_len,
    input  logic              mem_ack,
    input  logic              mem_rvalid,
    input  logic [7:0]        mem_rdata,
    input  logic              mem_rerr,
    output logic              tx_valid,
    output logic [7:0]        tx_data,
    input  logic              tx_ready,
    output logic              irq_o,
    output logic [1:0]        own_o,
    output logic [1:0]        done_o,
    output logic [1:0]        berr_o,
    output logic [ADDR_W-1:0] err_addr_o
);
    seq_st_t           st;
    logic              sel_q, sel_n, start, b_run;
    logic [LEN_W-1:0]  len_q;
    logic [1:0]        cmpl, app_v, term_v;
    logic [ADDR_W-1:0] base_v [2];
    logic [CNT_W-1:0]  cnt_v  [2];
    logic [CNT_W-1:0]  sent_v [2];
    logic [CNT_W-1:0]  rem_v  [2];
    logic [LEN_W-1:0]  blen_v [2];
    logic              burst_idle, burst_ok, burst_fail;
    logic              wr_term, wr_eoi;

    assign wr_term = host_wr && (host_addr == REG_CMD) && host_wdata[0];
    assign wr_eoi  = host_wr && (host_addr == REG_EOI);
    assign irq_o   = |berr_o;

    for (genvar g = 0; g < 2; g++) begin : g_buf
        localparam logic [2:0] OFF = 3'(REGS_PER_BUF * g);
        assign rem_v[g]  = (cnt_v[g] > sent_v[g]) ? (cnt_v[g] - sent_v[g]) : '0;
        assign blen_v[g] = (rem_v[g] >= CNT_W'(BURST)) ? LEN_W'(BURST) : rem_v[g][LEN_W-1:0];
        dbtx_bufctl #(
            .ADDR_W(ADDR_W), .CNT_W(CNT_W), .HOST_W(HOST_W), .LEN_W(LEN_W),
            .APPEND_OK(g == 0)
        ) i_buf (
            .clk(clk), .rst_n(rst_n),
            .wr_base(host_wr && host_addr == OFF),
            .wr_cnt(host_wr && host_addr == OFF + 3'd1),
            .wr_stat(host_wr && host_addr == OFF + 3'd2),
            .wr_term(wr_term), .wr_eoi(wr_eoi), .wdata(host_wdata),
            .ev_adv(burst_ok && sel_q == 1'(g)), .adv_len(len_q),
            .ev_complete(cmpl[g]), .ev_err(burst_fail && sel_q == 1'(g)),
            .base(base_v[g]), .cnt(cnt_v[g]), .sent(sent_v[g]),
            .own(own_o[g]), .append(app_v[g]), .term(term_v[g]),
            .done(done_o[g]), .berr(berr_o[g])
        );
    end

    // Selection cycle: decides the next burst or buffer release.
    always_comb begin
        start = 1'b0; sel_n = 1'b0; cmpl = 2'b00;
        if (st == ST_PICK && burst_idle) begin
            if (b_run && own_o[1] && rem_v[1] != '0) begin
                start = 1'b1; sel_n = 1'b1;
            end else if (b_run && own_o[1]) begin
                cmpl[1] = 1'b1;
            end else if (own_o[0] && rem_v[0] != '0) begin
                start = 1'b1;
            end else if (own_o[0] && (!app_v[0] || term_v[0])) begin
                cmpl[0] = 1'b1;
            end else if (own_o[1] && rem_v[1] != '0) begin
                start = 1'b1; sel_n = 1'b1;
            end else if (own_o[1]) begin
                cmpl[1] = 1'b1;
            end
        end
    end

    // Sequencer state: selection, burst in flight, error wait.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= ST_PICK; sel_q <= 1'b0; b_run <= 1'b0; len_q <= '0;
        end else begin
            unique case (st)
                ST_PICK: if (burst_idle) begin
                    b_run <= start && sel_n;
                    if (start) begin
                        sel_q <= sel_n; len_q <= blen_v[sel_n]; st <= ST_RUN;
                    end
                end
                ST_RUN: if (burst_fail) st <= ST_ERR;
                        else if (burst_ok) st <= ST_PICK;
                ST_ERR: if (wr_eoi) st <= ST_PICK;
                default: st <= ST_PICK;
            endcase
        end
    end

    dbtx_burst #(.ADDR_W(ADDR_W), .BURST(BURST), .LEN_W(LEN_W)) i_burst (
        .clk(clk), .rst_n(rst_n), .start(start),
        .start_addr(base_v[sel_n] + ADDR_W'(sent_v[sel_n])),
        .start_len(blen_v[sel_n]),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_len(mem_len), .mem_ack(mem_ack),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .mem_rerr(mem_rerr),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
        .idle(burst_idle), .done_ok(burst_ok), .fail(burst_fail)
    );
    assign err_addr_o = mem_addr;

    // R9
    no_read_in_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|berr_o) |-> !mem_req);
    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (!mem_req && !tx_valid && own_o == 2'b00));
endmodule

// File: tb/test_dual_buf_txdma.sv
module test_dual_buf_txdma;
    localparam int ADDR_W = 16, CNT_W = 16, HOST_W = 16, BURST = 16, LEN_W = 5;

    logic clk = 1'b0, rst_n = 1'b0;
    logic host_wr = 1'b0;
    logic [2:0] host_addr = '0;
    logic [HOST_W-1:0] host_wdata = '0;
    logic mem_req, mem_ack, mem_rvalid = 1'b0, mem_rerr = 1'b0;
    logic [ADDR_W-1:0] mem_addr, err_addr_o;
    logic [LEN_W-1:0] mem_len;
    logic [7:0] mem_rdata = '0, tx_data;
    logic tx_valid, tx_ready, irq_o;
    logic [1:0] own_o, done_o, berr_o, rdy_ph = '0;

    int checks = 0, errors = 0;
    logic [7:0] exp_q [$];
    string tag_q [$];
    logic [ADDR_W+LEN_W-1:0] req_log [$];

    logic m_busy = 1'b0, m_fail = 1'b0, err_arm = 1'b0;
    logic [ADDR_W-1:0] m_addr = '0, err_at = '0;
    logic [LEN_W-1:0] m_left = '0;

    always #2 clk = ~clk;

    assign mem_ack  = mem_req;
    assign tx_ready = (rdy_ph != 2'd3);

    dual_buf_txdma i_dual_buf_txdma (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_addr(host_addr),
        .host_wdata(host_wdata), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_len(mem_len), .mem_ack(mem_ack), .mem_rvalid(mem_rvalid),
        .mem_rdata(mem_rdata), .mem_rerr(mem_rerr), .tx_valid(tx_valid),
        .tx_data(tx_data), .tx_ready(tx_ready), .irq_o(irq_o), .own_o(own_o),
        .done_o(done_o), .berr_o(berr_o), .err_addr_o(err_addr_o)
    );

    function automatic logic [7:0] pat(input logic [15:0] a);
        return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'h3C;
    endfunction

    // Memory model: one beat per cycle, optional one-shot error at err_at.
    always @(posedge clk) begin
        rdy_ph <= rdy_ph + 2'd1;
        mem_rvalid <= 1'b0;
        mem_rerr   <= 1'b0;
        if (!m_busy && mem_req && mem_ack) begin
            m_busy <= 1'b1; m_addr <= mem_addr; m_left <= mem_len;
            m_fail <= err_arm && (mem_addr == err_at);
        end else if (m_busy) begin
            mem_rvalid <= 1'b1;
            mem_rdata  <= pat(m_addr);
            mem_rerr   <= m_fail;
            m_addr <= m_addr + 16'd1;
            m_left <= m_left - 5'd1;
            if (m_left == 5'd1 || m_fail) begin
                m_busy <= 1'b0;
                if (m_fail) err_arm <= 1'b0;
            end
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Scoreboard monitor: each accepted byte is compared with the queue front.
    always @(negedge clk) begin
        if (rst_n && mem_req) req_log.push_back({mem_addr, mem_len});
        if (rst_n && tx_valid && tx_ready) begin
            if (exp_q.size() == 0) chk("R4 unexpected byte", {24'd0, tx_data}, 32'hFFFF_FFFF);
            else chk(tag_q.pop_front(), {24'd0, tx_data}, {24'd0, exp_q.pop_front()});
        end
    end

    task automatic push_bytes(input logic [15:0] base, input int from, input int n, input string tag);
        for (int i = 0; i < n; i++) begin
            exp_q.push_back(pat(base + 16'(from + i)));
            tag_q.push_back(tag);
        end
    endtask

    task automatic hw(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        host_wr = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic drain(input int extra);
        int n = 0;
        while (exp_q.size() != 0 && n < 20000) begin @(negedge clk); n++; end
        repeat (extra) @(negedge clk);
    endtask

    task automatic wait_irq;
        int n = 0;
        while (!irq_o && n < 2000) begin @(negedge clk); n++; end
    endtask

    task automatic summary;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not complete");
        summary();
    end

    initial begin
        repeat (5) @(negedge clk);
        // R1 reset state
        chk("R1 mem_req", {31'd0, mem_req}, 0);
        chk("R1 tx_valid", {31'd0, tx_valid}, 0);
        chk("R1 flags", {25'd0, irq_o, own_o, done_o, berr_o}, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R2 R3 R5: plain B buffer of 20 bytes at 0x0100
        hw(3'd3, 16'h0100); hw(3'd4, 16'd20);
        push_bytes(16'h0100, 0, 20, "R5 B bytes");
        req_log.delete();
        hw(3'd5, 16'h0001);
        drain(10);
        chk("R3 first burst", {11'd0, req_log[0]}, {11'd0, 16'h0100, 5'd16});
        chk("R3 second burst", {11'd0, req_log[1]}, {11'd0, 16'h0110, 5'd4});
        chk("R5 B own cleared", {31'd0, own_o[1]}, 0);
        chk("R5 B done", {31'd0, done_o[1]}, 1);

        // R6: growing A from count 0
        hw(3'd0, 16'h0400); hw(3'd1, 16'd0);
        req_log.delete();
        hw(3'd2, 16'h0003);
        repeat (60) @(negedge clk);
        chk("R6 no read at count 0", req_log.size(), 0);
        chk("R6 A owned", {31'd0, own_o[0]}, 1);
        push_bytes(16'h0400, 0, 5, "R6 A bytes");
        hw(3'd1, 16'd5);
        drain(10);
        chk("R6 A still owned", {31'd0, own_o[0]}, 1);
        chk("R6 A not done", {31'd0, done_o[0]}, 0);
        push_bytes(16'h0400, 5, 4, "R6 A more bytes");
        hw(3'd1, 16'd9);
        drain(10);

        // R7: B runs to the end while A grows
        hw(3'd3, 16'h0200); hw(3'd4, 16'd40);
        push_bytes(16'h0200, 0, 40, "R7 B bytes");
        hw(3'd5, 16'h0001);
        while (exp_q.size() > 30) @(negedge clk);
        push_bytes(16'h0400, 9, 3, "R7 A after B");
        hw(3'd1, 16'd12);
        drain(10);
        chk("R7 B done", {31'd0, done_o[1]}, 1);
        chk("R7 A still owned", {31'd0, own_o[0]}, 1);

        // R8: terminate after pending bytes
        push_bytes(16'h0400, 12, 3, "R8 A last bytes");
        hw(3'd1, 16'd15);
        hw(3'd6, 16'h0001);
        drain(10);
        chk("R8 A released", {31'd0, own_o[0]}, 0);
        chk("R8 A done", {31'd0, done_o[0]}, 1);

        // R9 R11: error on second B burst, then retry
        hw(3'd3, 16'h0300); hw(3'd4, 16'd20);
        err_at = 16'h0310; err_arm = 1'b1;
        push_bytes(16'h0300, 0, 16, "R9 B first burst");
        hw(3'd5, 16'h0001);
        wait_irq();
        @(negedge clk);
        chk("R9 irq", {31'd0, irq_o}, 1);
        chk("R9 berr B", {30'd0, berr_o}, 2);
        chk("R9 own B cleared", {31'd0, own_o[1]}, 0);
        chk("R9 error address", {16'd0, err_addr_o}, {16'd0, 16'h0310});
        chk("R9 no failed bytes left", exp_q.size(), 0);
        req_log.delete();
        repeat (20) @(negedge clk);
        chk("R9 no reads while pending", req_log.size(), 0);
        push_bytes(16'h0300, 16, 4, "R11 retried bytes");
        hw(3'd5, 16'h0001);
        hw(3'd7, 16'h0000);
        drain(10);
        chk("R11 retry address", {11'd0, req_log[0]}, {11'd0, 16'h0310, 5'd4});
        chk("R11 irq cleared", {31'd0, irq_o}, 0);
        chk("R11 B done", {31'd0, done_o[1]}, 1);

        // R10: error on plain A, then discard
        hw(3'd0, 16'h0500); hw(3'd1, 16'd8);
        err_at = 16'h0500; err_arm = 1'b1;
        hw(3'd2, 16'h0001);
        wait_irq();
        @(negedge clk);
        chk("R9 A error address", {16'd0, err_addr_o}, {16'd0, 16'h0500});
        chk("R9 berr A", {30'd0, berr_o}, 1);
        hw(3'd7, 16'h0001);
        req_log.delete();
        repeat (30) @(negedge clk);
        chk("R10 irq cleared", {31'd0, irq_o}, 0);
        chk("R10 berr cleared", {30'd0, berr_o}, 0);
        chk("R10 A unowned", {31'd0, own_o[0]}, 0);
        chk("R10 A not done", {31'd0, done_o[0]}, 0);
        chk("R10 no further reads", req_log.size(), 0);
        summary();
    end
endmodule